// File: doc/BRIEF.md
# Menu and Annotation Overlay Arbiter

This block sits between the display pixel stream, two auxiliary memories and a CPU. One memory holds a single flag bit per pixel that marks the image. The other holds the menu graphics, one value per pixel. While the video is in its active scan, the block owns both memories. It reads them at the address of each incoming image pixel and emits a composite pixel. A menu value that is not zero wins. Otherwise a set mark forces full white. Otherwise the image value passes through.

During retrace the block hands both memories to the CPU, so software can redraw the menu and the marks. Ownership changes only at a scan/retrace boundary, and one idle clock lies between the two owners. A CPU request made during scan is not lost. It is held off with a wait indication until retrace grants the bus. During scan the CPU is expected to work only on the frame and work memories, which lie outside this block.

Pixel input and composite output are valid/ready streams. A beat moves on a rising edge where valid and ready are both high. The source must hold valid, address and data stable until it is accepted. The output holds valid and data stable while ready is low. Back-pressure at the output stops input acceptance once the two internal stages are full.

Top module: `overlay_arbiter`

## Requirements
- R1: While rst_n is low, out_valid, cpu_ack and pix_ready are all 0.
- R2: When the menu value read for a pixel's address is not zero, the composite output equals that menu value, whatever the mark or image value.
- R3: When the menu value is zero and bit 0 of the mark memory at that address is 1, the composite output is all ones.
- R4: When the menu value is zero and the mark bit is 0, the composite output equals the image value unchanged.
- R5: The output is a stream. While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable. At most two accepted pixels are pending output. Outputs leave in acceptance order.
- R6: pix_ready is high only while scan_active is high. No pixel is accepted during retrace.
- R7: During retrace a held cpu_req performs one access and completes with a one-cycle cpu_ack. The access is a write when cpu_we is 1 and a read when cpu_we is 0. cpu_sel = 0 selects the mark memory: bit 0 of cpu_wdata is written, and a read returns the flag in bit 0 with the upper bits 0. cpu_sel = 1 selects the menu memory with the full width. Read data is valid on cpu_rdata during the cpu_ack cycle.
- R8: A cpu_req raised during scan gets no cpu_ack while scan lasts. cpu_wait stays high until the ack.
- R9: Ownership passes through one idle clock. With the pixel stages empty and a request pending, cpu_ack appears on the third clock after scan_active falls. cpu_ack never comes earlier than the third clock after the last accepted pixel.
- R10: The memories are written only for a CPU request during retrace. ann_we or menu_we high implies cpu_req high and scan_active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_active | input | 1 | 1 in active scan, 0 in retrace |
| pix_valid | input | 1 | Image pixel valid |
| pix_ready | output | 1 | Image pixel accepted this cycle if valid |
| pix_addr | input | ADDR_W | Display address of the pixel |
| pix_data | input | PIX_W | Image pixel value |
| out_valid | output | 1 | Composite pixel valid |
| out_ready | input | 1 | Downstream can take the composite pixel |
| out_data | output | PIX_W | Composite pixel value |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_sel | input | 1 | 0 = mark memory, 1 = menu memory |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU memory address |
| cpu_wdata | input | PIX_W | CPU write data |
| cpu_rdata | output | PIX_W | CPU read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | Request pending and not yet served |
| ann_en | output | 1 | Mark memory enable |
| ann_we | output | 1 | Mark memory write enable |
| ann_addr | output | ADDR_W | Mark memory address |
| ann_wdata | output | 1 | Mark memory write bit |
| ann_rdata | input | 1 | Mark memory read bit |
| menu_en | output | 1 | Menu memory enable |
| menu_we | output | 1 | Menu memory write enable |
| menu_addr | output | ADDR_W | Menu memory address |
| menu_wdata | output | PIX_W | Menu memory write data |
| menu_rdata | input | PIX_W | Menu memory read data |

## Verification
The assertions assume synchronous memories with one clock of read latency. They also assume the memories hold their read data on clocks without an enable, and that scan_active is synchronous to clk. They further take it that the CPU keeps its select, direction, address and data stable from request to ack, and that the pixel source holds its beat until it is accepted. The stimulus follows these rules. It uses behavioural memories with exactly that read timing. It raises scan_active only with the pixel source idle, drops it only after the source has finished, and changes CPU fields only between transfers.

// File: rtl/overlay_pkg.sv
package overlay_pkg;
  typedef enum logic [1:0] {
    OWN_GAP  = 2'd0,
    OWN_DISP = 2'd1,
    OWN_CPU  = 2'd2
  } owner_e;
endpackage

// File: rtl/ovl_owner_fsm.sv
module ovl_owner_fsm
  import overlay_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   scan_active,
  input  logic   disp_busy,
  input  logic   cpu_busy,
  output owner_e owner
);
  owner_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OWN_GAP;
    end else begin
      case (state_q)
        OWN_GAP:  state_q <= scan_active ? OWN_DISP : OWN_CPU;
        OWN_DISP: if (!scan_active && !disp_busy) state_q <= OWN_GAP;
        OWN_CPU:  if (scan_active && !cpu_busy) state_q <= OWN_GAP;
        default:  state_q <= OWN_GAP;
      endcase
    end
  end

  assign owner = state_q;
endmodule

// File: rtl/ovl_disp_pipe.sv
module ovl_disp_pipe #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             rd_fire,
  input  logic [PIX_W-1:0] menu_rdata,
  input  logic             ann_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             busy
);
  localparam logic [PIX_W-1:0] WHITE = {PIX_W{1'b1}};

  logic             s1_valid;
  logic [PIX_W-1:0] s1_pix;
  logic             ov_q;
  logic [PIX_W-1:0] od_q;
  logic             load_out;
  logic [PIX_W-1:0] merged;

  assign load_out  = s1_valid && (!ov_q || out_ready);
  assign pix_ready = enable && (!s1_valid || load_out);
  assign rd_fire   = pix_valid && pix_ready;

  always_comb begin
    if (menu_rdata != '0)  merged = menu_rdata;
    else if (ann_rdata)    merged = WHITE;
    else                   merged = s1_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
    end else begin
      if (rd_fire) begin
        s1_valid <= 1'b1;
        s1_pix   <= pix_data;
      end else if (load_out) begin
        s1_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (load_out) begin
      ov_q <= 1'b1;
      od_q <= merged;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign busy      = s1_valid;
endmodule

// File: rtl/ovl_cpu_port.sv
module ovl_cpu_port #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             scan_active,
  input  logic             cpu_req,
  input  logic             cpu_sel,
  input  logic [PIX_W-1:0] menu_rdata,
  input  logic             ann_rdata,
  output logic             issue,
  output logic             cpu_ack,
  output logic             cpu_wait,
  output logic [PIX_W-1:0] cpu_rdata,
  output logic             busy
);
  logic ack_q;
  logic sel_q;

  assign issue = grant && !scan_active && cpu_req && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      ack_q <= issue;
      if (issue) sel_q <= cpu_sel;
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_wait  = cpu_req && !ack_q;
  assign cpu_rdata = sel_q ? menu_rdata : {{(PIX_W-1){1'b0}}, ann_rdata};
  assign busy      = ack_q;
endmodule

// File: rtl/overlay_arbiter.sv
module overlay_arbiter
  import overlay_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_active,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data,
  input  logic              cpu_req,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [PIX_W-1:0]  cpu_wdata,
  output logic [PIX_W-1:0]  cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_wait,
  output logic              ann_en,
  output logic              ann_we,
  output logic [ADDR_W-1:0] ann_addr,
  output logic              ann_wdata,
  input  logic              ann_rdata,
  output logic              menu_en,
  output logic              menu_we,
  output logic [ADDR_W-1:0] menu_addr,
  output logic [PIX_W-1:0]  menu_wdata,
  input  logic [PIX_W-1:0]  menu_rdata
);
  owner_e            owner;
  logic              disp_busy, cpu_busy;
  logic              disp_fire, cpu_issue;
  logic [ADDR_W-1:0] bus_addr;

  ovl_owner_fsm u_owner (
    .clk, .rst_n, .scan_active,
    .disp_busy (disp_busy),
    .cpu_busy  (cpu_busy),
    .owner     (owner)
  );

  ovl_disp_pipe #(.PIX_W(PIX_W)) u_disp (
    .clk, .rst_n,
    .enable     (owner == OWN_DISP && scan_active),
    .pix_valid, .pix_data, .pix_ready,
    .rd_fire    (disp_fire),
    .menu_rdata, .ann_rdata,
    .out_valid, .out_ready, .out_data,
    .busy       (disp_busy)
  );

  ovl_cpu_port #(.PIX_W(PIX_W)) u_cpu (
    .clk, .rst_n,
    .grant      (owner == OWN_CPU),
    .scan_active, .cpu_req, .cpu_sel,
    .menu_rdata, .ann_rdata,
    .issue      (cpu_issue),
    .cpu_ack, .cpu_wait, .cpu_rdata,
    .busy       (cpu_busy)
  );

  assign bus_addr   = (owner == OWN_DISP) ? pix_addr : cpu_addr;
  assign ann_addr   = bus_addr;
  assign menu_addr  = bus_addr;
  assign ann_en     = disp_fire || (cpu_issue && !cpu_sel);
  assign menu_en    = disp_fire || (cpu_issue && cpu_sel);
  assign ann_we     = cpu_issue && !cpu_sel && cpu_we;
  assign menu_we    = cpu_issue && cpu_sel && cpu_we;
  assign ann_wdata  = cpu_wdata[0];
  assign menu_wdata = cpu_wdata;
endmodule

// File: rtl/overlay_arbiter_chk.sv
module overlay_arbiter_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_active,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             cpu_req,
  input logic             cpu_ack,
  input logic             ann_en,
  input logic             ann_we,
  input logic             menu_en,
  input logic             menu_we
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_NO_ACK_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active && $past(scan_active) |-> !cpu_ack); // R8

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R7

  AST_NO_SHARED_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ready && cpu_ack)); // R9

  AST_WRITE_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (ann_we || menu_we) |-> cpu_req && !scan_active); // R10

  AST_ENABLE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ann_en || menu_en) |-> (pix_valid && pix_ready) || (cpu_req && !cpu_ack)); // R9
endmodule

bind overlay_arbiter overlay_arbiter_chk #(.PIX_W(PIX_W)) chk_i (.*);

// File: tb/overlay_arbiter_tb_top.sv
`timescale 1ns/100ps
module overlay_arbiter_tb_top;
  localparam int AW = 6;
  localparam int PW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, scan_active, pix_valid, pix_ready, out_valid, out_ready;
  logic [AW-1:0] pix_addr, cpu_addr, ann_addr, menu_addr;
  logic [PW-1:0] pix_data, out_data, cpu_wdata, cpu_rdata, menu_wdata, menu_rdata;
  logic          cpu_req, cpu_sel, cpu_we, cpu_ack, cpu_wait;
  logic          ann_en, ann_we, ann_wdata, ann_rdata, menu_en, menu_we;

  overlay_arbiter #(.ADDR_W(AW), .PIX_W(PW)) dut_i (.*);

  logic          ann_ram [DEPTH];
  logic [PW-1:0] menu_ram [DEPTH];
  logic          ann_sh [DEPTH];
  logic [PW-1:0] menu_sh [DEPTH];

  always @(posedge clk) begin
    if (ann_en) begin
      if (ann_we) ann_ram[ann_addr] <= ann_wdata;
      ann_rdata <= ann_ram[ann_addr];
    end
    if (menu_en) begin
      if (menu_we) menu_ram[menu_addr] <= menu_wdata;
      menu_rdata <= menu_ram[menu_addr];
    end
  end

  int errors = 0, checks = 0, cyc = 0;
  int stream_idx = 0, stream_end = 0, rdy_mode = 0, last_fire = -100;
  bit stream_on = 0, hold_pend = 0;
  logic [PW-1:0] hold_val;
  logic [PW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic logic [PW-1:0] img(input int i);
    return PW'(i * 7 + 3);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one clock: drive at the falling edge, then compare against the reference
  task automatic tick();
    @(negedge clk);
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    pix_valid = stream_on && (stream_idx < stream_end);
    pix_addr  = AW'(stream_idx);
    pix_data  = img(stream_idx);
    #1;
    if (hold_pend)
      chk(out_valid && out_data == hold_val, "R5 hold", int'(out_data), int'(hold_val));
    hold_pend = out_valid && !out_ready;
    hold_val  = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected output", int'(out_data), 0);
      else begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e, t, int'(out_data), int'(e));
      end
    end
    if (pix_valid && !scan_active)
      chk(!pix_ready, "R6 accept in retrace", int'(pix_ready), 0);
    if (pix_valid && pix_ready) begin
      int a;
      a = stream_idx;
      if (menu_sh[a] != 0) begin exp_q.push_back(menu_sh[a]); tag_q.push_back("R2 menu"); end
      else if (ann_sh[a])  begin exp_q.push_back('1);         tag_q.push_back("R3 mark"); end
      else                 begin exp_q.push_back(img(a));     tag_q.push_back("R4 image"); end
      stream_idx++;
      last_fire = cyc;
    end
    if (exp_q.size() > 2) chk(1'b0, "R5 in flight", exp_q.size(), 2);
    if (cpu_ack) chk(cyc - last_fire >= 3, "R9 gap", cyc - last_fire, 3);
    if (ann_we || menu_we)
      chk(cpu_req && !scan_active, "R10 write source", int'(scan_active), 0);
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "watchdog", cyc, 50000);
      finish_run();
    end
  endtask

  task automatic cpu_xfer(input bit sel, input bit we, input int addr,
                          input logic [PW-1:0] wd, output logic [PW-1:0] rd, output int n);
    cpu_sel = sel; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd; cpu_req = 1'b1;
    n = 0;
    forever begin
      tick();
      n++;
      if (cpu_ack) begin rd = cpu_rdata; break; end
      if (n > 500) begin chk(1'b0, "R7 no ack", n, 0); break; end
    end
    cpu_req = 1'b0;
    if (we) begin
      if (sel) menu_sh[addr] = wd;
      else     ann_sh[addr]  = wd[0];
    end
  endtask

  task automatic run_stream(input int first, input int last);
    stream_idx = first; stream_end = last + 1; stream_on = 1;
    for (int k = 0; k < 2000; k++) begin
      tick();
      if (stream_idx > last && exp_q.size() == 0) break;
    end
    stream_on = 0;
    chk(exp_q.size() == 0 && stream_idx == last + 1, "R5 stream drained", exp_q.size(), 0);
  endtask

  initial begin
    logic [PW-1:0] rd;
    int n;
    for (int i = 0; i < DEPTH; i++) begin
      ann_ram[i] = 0; menu_ram[i] = 0; ann_sh[i] = 0; menu_sh[i] = 0;
    end
    ann_rdata = 0; menu_rdata = 0;
    rst_n = 0; scan_active = 0; pix_valid = 0; pix_addr = 0; pix_data = 0; out_ready = 1;
    cpu_req = 0; cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!cpu_ack, "R1 cpu_ack", int'(cpu_ack), 0);
    chk(!pix_ready, "R1 pix_ready", int'(pix_ready), 0);
    rst_n = 1;
    repeat (3) tick();

    // retrace: CPU draws menu and marks (R7)
    cpu_xfer(1, 1, 5, 8'h5A, rd, n);
    cpu_xfer(0, 1, 5, 8'h01, rd, n);
    cpu_xfer(0, 1, 9, 8'hFF, rd, n);
    cpu_xfer(0, 1, 12, 8'h01, rd, n);
    cpu_xfer(1, 1, 40, 8'h81, rd, n);
    cpu_xfer(0, 1, 41, 8'h01, rd, n);
    cpu_xfer(1, 1, 9, 8'h00, rd, n);
    cpu_xfer(1, 0, 5, 8'h00, rd, n);
    chk(rd == 8'h5A, "R7 menu read", int'(rd), 'h5A);
    cpu_xfer(0, 0, 9, 8'h00, rd, n);
    chk(rd == 8'h01, "R7 mark read", int'(rd), 1);
    cpu_xfer(0, 0, 20, 8'h00, rd, n);
    chk(rd == 8'h00, "R7 clear mark read", int'(rd), 0);
    tick();
    chk(!cpu_ack, "R7 ack one cycle", int'(cpu_ack), 0);

    // retrace: pixel offered, must not be taken (R6)
    stream_idx = 0; stream_end = 4; stream_on = 1;
    repeat (5) tick();
    stream_on = 0;
    chk(stream_idx == 0, "R6 no retrace accept", stream_idx, 0);

    // scan: full-rate then throttled output (R2 R3 R4 R5)
    scan_active = 1;
    repeat (3) tick();
    rdy_mode = 0;
    run_stream(0, 31);
    rdy_mode = 1;
    stream_idx = 32; stream_end = 64; stream_on = 1;
    repeat (6) tick();
    rdy_mode = 2;
    repeat (6) tick();
    chk(!pix_ready && exp_q.size() == 2, "R5 stall", exp_q.size(), 2);
    rdy_mode = 1;
    stream_on = 0;
    run_stream(stream_idx, 63);
    rdy_mode = 0;
    repeat (3) tick();

    // CPU request during scan is held off (R8), then served after the gap (R9)
    cpu_sel = 1; cpu_we = 0; cpu_addr = AW'(40); cpu_req = 1;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (k == 0 || k == 9)
        chk(!cpu_ack && cpu_wait, "R8 held off", int'(cpu_ack), 0);
    end
    scan_active = 0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      n++;
      if (cpu_ack) begin rd = cpu_rdata; break; end
    end
    cpu_req = 0;
    chk(n == 3, "R9 ack latency", n, 3);
    chk(rd == 8'h81, "R7 deferred read", int'(rd), 'h81);
    tick();
    chk(!cpu_wait, "R8 wait cleared", int'(cpu_wait), 0);

    // second frame after retrace: ownership returns to display
    scan_active = 1;
    repeat (3) tick();
    rdy_mode = 1;
    run_stream(0, 15);
    run_stream(38, 45);
    finish_run();
  end
endmodule